// File: doc/BRIEF.md
# Shared Serial Port Pin Controller

This block decides, pin by pin, who drives a group of eleven shared pads: a synchronous serial peripheral engine, two asynchronous serial channels, or software through a general-purpose parallel port. A twelfth pad carries an external clock. It is never multiplexed and is passed straight through. Software uses a small synchronous register bus to program four registers. These are a port data latch, an ownership mask for the seven serial-peripheral pins, a direction mask for the same seven pins, and a 5-bit interrupt priority level for the serial peripheral.

The serial peripheral supplies an output value and an output-enable request for each of its pins. The block combines these with the ownership and direction masks and produces one output-data and one output-enable vector for the pad ring. It also returns the pad samples to the engines. Each asynchronous channel claims its transmit pad through its transmitter-enable flag and its receive pad through its receiver-enable flag. The ownership mask has no effect on those four pads.

Pin indices are fixed. Pins 0 to 6 are serial-peripheral pins. Pins 7 and 8 are the transmit pads of channels 0 and 1. Pins 9 and 10 are the receive pads of channels 0 and 1.

Top module: `ssp_pinctl`

## Requirements
- R1: After reset the four registers read zero, the serial-peripheral pins are inputs (pin_oe[6:0]=0) and the level output is 0.
- R2: A serial-peripheral pin whose ownership bit is 0 drives its port data latch bit, and its output enable equals its direction bit (1 = output, 0 = input).
- R3: A serial-peripheral pin whose ownership bit is 1 drives spi_do. Its output enable is the direction bit ANDed with spi_oe, and spi_di returns the pad sample. spi_di is 0 for a pin whose ownership bit is 0.
- R4: A transmit pad is always enabled as an output. It carries uart_txd while its transmitter-enable flag is 1, and its port data latch bit otherwise, whatever the ownership mask holds.
- R5: A receive pad is never enabled as an output. uart_rxd returns the pad sample while the receiver-enable flag is 1, and idles at 1 otherwise.
- R6: A read of the port data register (halfword offset 0x14) returns, in bits 10:0, the latch for pins that are outputs and the pad sample for pins that are inputs. Transmit pads count as outputs, receive pads count as inputs, and bits 15:11 read 0.
- R7: A port data write updates the latch even for pins owned by a peripheral. The value appears on the pin once the pin returns to general-purpose use.
- R8: Halfword offset 0x16 carries the ownership mask in bits 14:8 (byte 0x16, enabled by bus_be[1]) and the direction mask in bits 6:0 (byte 0x17, enabled by bus_be[0]). Bits 15 and 7 read 0. Byte enable bus_be[1] selects wdata[15:8] and bus_be[0] selects wdata[7:0] at every offset.
- R9: The interrupt level lives at halfword offset 0x06 in bits 4:0, from 0 (lowest) to 31 (highest), and is driven on spi_irq_lvl. Bits 15:5 read 0.
- R10: Reads of any other offset return 0, and writes to them change nothing. bus_rdata is 0 unless bus_sel=1 and bus_we=0. bus_addr[0] is ignored.
- R11: A write takes effect at the clock edge that samples the strobe, and a read in the following cycle returns the new value.
- R12: xclk_out follows xclk_pin combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the block window |
| bus_be | input | 2 | Byte enables: [1] = bits 15:8, [0] = bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| spi_irq_lvl | output | 5 | Programmed interrupt level |
| spi_do | input | 7 | Serial-peripheral pin output values |
| spi_oe | input | 7 | Serial-peripheral output enable requests |
| spi_di | output | 7 | Pad samples returned to the serial peripheral |
| uart_txd | input | 2 | Transmit data of channels 1:0 |
| uart_tx_en | input | 2 | Transmitter enable flags |
| uart_rx_en | input | 2 | Receiver enable flags |
| uart_rxd | output | 2 | Receive data returned to channels 1:0 |
| pin_in | input | 11 | Pad input samples |
| pin_out | output | 11 | Pad output data |
| pin_oe | output | 11 | Pad output enables |
| xclk_pin | input | 1 | External clock pad |
| xclk_out | output | 1 | External clock to the serial subsystems |

## Verification
The only state in the block is its four registers, and every bit of them reaches the ports in the cycle after it is written. A corrupted latch, ownership or direction bit shows up at once on pin_out, pin_oe or a port data read-back. A corrupted level shows on spi_irq_lvl. A fault in the pin multiplexer is combinational, so it appears in the same cycle as the input pattern that exposes it. For that reason every output is compared against a model on every cycle, including while enable flags and pad samples change under a fixed configuration.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SPI_PINS = 7;
    localparam int UART_CH  = 2;
    localparam int MUX_PINS = SPI_PINS + 2 * UART_CH;
    localparam int LVL_W    = 5;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int BE_W     = DATA_W / 8;
    localparam int HW_W     = ADDR_W - 1;

    // byte offsets of the register window
    localparam logic [ADDR_W-1:0] OFS_LVL  = 8'h06;
    localparam logic [ADDR_W-1:0] OFS_PORT = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h16;

    localparam logic [HW_W-1:0] HW_LVL  = OFS_LVL[ADDR_W-1:1];
    localparam logic [HW_W-1:0] HW_PORT = OFS_PORT[ADDR_W-1:1];
    localparam logic [HW_W-1:0] HW_CFG  = OFS_CFG[ADDR_W-1:1];

    // ownership mask sits in the upper byte of the config halfword
    localparam int OWN_LSB = 8;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [HW_W-1:0]   hw;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [MUX_PINS-1:0] port;
        logic [SPI_PINS-1:0] own;
        logic [SPI_PINS-1:0] dir;
        logic [LVL_W-1:0]    lvl;
    } ssp_cfg_t;

    function automatic int tx_pin(input int ch);
        return SPI_PINS + ch;
    endfunction

    function automatic int rx_pin(input int ch);
        return SPI_PINS + UART_CH + ch;
    endfunction

endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
    import ssp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            req,
    input  logic [MUX_PINS-1:0] port_rd,
    output logic [DATA_W-1:0]   rdata,
    output ssp_cfg_t            cfg
);

    logic wr_go;
    logic rd_go;

    assign wr_go = req.sel & req.we;
    assign rd_go = req.sel & ~req.we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_go) begin
            case (req.hw)
                HW_PORT: begin
                    for (int b = 0; b < MUX_PINS; b++) begin
                        if (req.be[b / 8]) cfg.port[b] <= req.wdata[b];
                    end
                end
                HW_CFG: begin
                    if (req.be[1]) cfg.own <= req.wdata[OWN_LSB +: SPI_PINS];
                    if (req.be[0]) cfg.dir <= req.wdata[0 +: SPI_PINS];
                end
                HW_LVL: begin
                    if (req.be[0]) cfg.lvl <= req.wdata[LVL_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_go) begin
            case (req.hw)
                HW_PORT: rdata[MUX_PINS-1:0] = port_rd;
                HW_CFG: begin
                    rdata[OWN_LSB +: SPI_PINS] = cfg.own;
                    rdata[0 +: SPI_PINS]       = cfg.dir;
                end
                HW_LVL:  rdata[LVL_W-1:0] = cfg.lvl;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ssp_pinmux.sv
module ssp_pinmux
    import ssp_pkg::*;
(
    input  ssp_cfg_t            cfg,
    input  logic [SPI_PINS-1:0] spi_do,
    input  logic [SPI_PINS-1:0] spi_oe,
    input  logic [UART_CH-1:0]  uart_txd,
    input  logic [UART_CH-1:0]  tx_en,
    input  logic [UART_CH-1:0]  rx_en,
    input  logic [MUX_PINS-1:0] pin_in,
    output logic [MUX_PINS-1:0] pin_out,
    output logic [MUX_PINS-1:0] pin_oe,
    output logic [SPI_PINS-1:0] spi_di,
    output logic [UART_CH-1:0]  uart_rxd,
    output logic [MUX_PINS-1:0] port_rd
);

    for (genvar i = 0; i < SPI_PINS; i++) begin : g_spi
        assign pin_out[i] = cfg.own[i] ? spi_do[i] : cfg.port[i];
        assign pin_oe[i]  = cfg.dir[i] & (~cfg.own[i] | spi_oe[i]);
        assign spi_di[i]  = cfg.own[i] & pin_in[i];
        assign port_rd[i] = cfg.dir[i] ? cfg.port[i] : pin_in[i];
    end

    for (genvar j = 0; j < UART_CH; j++) begin : g_uart
        localparam int TP = tx_pin(j);
        localparam int RP = rx_pin(j);

        assign pin_out[TP] = tx_en[j] ? uart_txd[j] : cfg.port[TP];
        assign pin_oe[TP]  = 1'b1;
        assign port_rd[TP] = cfg.port[TP];

        assign pin_out[RP] = cfg.port[RP];
        assign pin_oe[RP]  = 1'b0;
        assign port_rd[RP] = pin_in[RP];
        assign uart_rxd[j] = rx_en[j] ? pin_in[RP] : 1'b1;
    end

endmodule

// File: rtl/ssp_pinctl.sv
module ssp_pinctl
    import ssp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BE_W-1:0]     bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [LVL_W-1:0]    spi_irq_lvl,
    input  logic [SPI_PINS-1:0] spi_do,
    input  logic [SPI_PINS-1:0] spi_oe,
    output logic [SPI_PINS-1:0] spi_di,
    input  logic [UART_CH-1:0]  uart_txd,
    input  logic [UART_CH-1:0]  uart_tx_en,
    input  logic [UART_CH-1:0]  uart_rx_en,
    output logic [UART_CH-1:0]  uart_rxd,
    input  logic [MUX_PINS-1:0] pin_in,
    output logic [MUX_PINS-1:0] pin_out,
    output logic [MUX_PINS-1:0] pin_oe,
    input  logic                xclk_pin,
    output logic                xclk_out
);

    bus_req_t            req;
    ssp_cfg_t            cfg;
    logic [MUX_PINS-1:0] port_rd;
    logic [SPI_PINS-1:0] dir_q;

    // bus_addr[0] selects a byte lane, which bus_be already encodes
    assign req.sel   = bus_sel;
    assign req.we    = bus_we;
    assign req.hw    = bus_addr[ADDR_W-1:1];
    assign req.be    = bus_be;
    assign req.wdata = bus_wdata;

    ssp_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .port_rd (port_rd),
        .rdata   (bus_rdata),
        .cfg     (cfg)
    );

    ssp_pinmux u_mux (
        .cfg      (cfg),
        .spi_do   (spi_do),
        .spi_oe   (spi_oe),
        .uart_txd (uart_txd),
        .tx_en    (uart_tx_en),
        .rx_en    (uart_rx_en),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .spi_di   (spi_di),
        .uart_rxd (uart_rxd),
        .port_rd  (port_rd)
    );

    assign spi_irq_lvl = cfg.lvl;
    assign dir_q       = cfg.dir;
    assign xclk_out    = xclk_pin;

    logic unused_addr0;
    assign unused_addr0 = bus_addr[0];

endmodule

// File: rtl/ssp_pinctl_chk.sv
module ssp_pinctl_chk
    import ssp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [BE_W-1:0]     bus_be,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [LVL_W-1:0]    spi_irq_lvl,
    input logic [UART_CH-1:0]  uart_txd,
    input logic [UART_CH-1:0]  uart_tx_en,
    input logic [MUX_PINS-1:0] pin_out,
    input logic [MUX_PINS-1:0] pin_oe,
    input logic [SPI_PINS-1:0] dir_q
);

    logic lvl_wr;
    assign lvl_wr = bus_sel && bus_we && (bus_addr[ADDR_W-1:1] == HW_LVL) && bus_be[0];

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (spi_irq_lvl == '0 && pin_oe[SPI_PINS-1:0] == '0));

    a_r2_oe_needs_dir: assert property (@(posedge clk) disable iff (rst)
        (pin_oe[SPI_PINS-1:0] & ~dir_q) == '0);

    a_r4_tx_follows: assert property (@(posedge clk) disable iff (rst)
        uart_tx_en[0] |-> pin_out[tx_pin(0)] == uart_txd[0]);

    a_r5_rx_never_driven: assert property (@(posedge clk) disable iff (rst)
        pin_oe[rx_pin(UART_CH-1):rx_pin(0)] == '0);

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr[ADDR_W-1:1] == HW_PORT)
            |-> bus_rdata[DATA_W-1:MUX_PINS] == '0);

    a_r10_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_we) |-> bus_rdata == '0);

    a_r11_lvl_next: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> spi_irq_lvl == $past(bus_wdata[LVL_W-1:0]));

    a_r9_lvl_holds: assert property (@(posedge clk) disable iff (rst)
        !lvl_wr |=> $stable(spi_irq_lvl));

endmodule

bind ssp_pinctl ssp_pinctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .spi_irq_lvl (spi_irq_lvl),
    .uart_txd    (uart_txd),
    .uart_tx_en  (uart_tx_en),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .dir_q       (dir_q)
);

// File: tb/sim_ssp_pinctl.sv
module sim_ssp_pinctl;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [4:0]  spi_irq_lvl;
    logic [6:0]  spi_do, spi_oe, spi_di;
    logic [1:0]  uart_txd, uart_tx_en, uart_rx_en, uart_rxd;
    logic [10:0] pin_in, pin_out, pin_oe;
    logic        xclk_pin, xclk_out;

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural reference state
    bit [10:0] m_port;
    bit [6:0]  m_own, m_dir;
    bit [4:0]  m_lvl;

    always #5 clk = ~clk;

    ssp_pinctl u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .spi_irq_lvl(spi_irq_lvl),
        .spi_do(spi_do), .spi_oe(spi_oe), .spi_di(spi_di),
        .uart_txd(uart_txd), .uart_tx_en(uart_tx_en), .uart_rx_en(uart_rx_en),
        .uart_rxd(uart_rxd), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .xclk_pin(xclk_pin), .xclk_out(xclk_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [10:0] e_out, e_oe, e_rd;
        logic [6:0]  e_di;
        logic [1:0]  e_rxd;
        logic [15:0] e_rdata;
        string       rtag;
        for (int i = 0; i < 7; i++) begin
            e_out[i] = m_own[i] ? spi_do[i] : m_port[i];
            e_oe[i]  = m_dir[i] && (!m_own[i] || spi_oe[i]);
            e_di[i]  = m_own[i] && pin_in[i];
            e_rd[i]  = m_dir[i] ? m_port[i] : pin_in[i];
        end
        for (int j = 0; j < 2; j++) begin
            e_out[7+j] = uart_tx_en[j] ? uart_txd[j] : m_port[7+j];
            e_oe[7+j]  = 1'b1;
            e_rd[7+j]  = m_port[7+j];
            e_out[9+j] = m_port[9+j];
            e_oe[9+j]  = 1'b0;
            e_rd[9+j]  = pin_in[9+j];
            e_rxd[j]   = uart_rx_en[j] ? pin_in[9+j] : 1'b1;
        end
        e_rdata = 16'h0;
        rtag = "R10";
        if (bus_sel && !bus_we) begin
            case (bus_addr[7:1])
                7'h0A: begin e_rdata = {5'h0, e_rd}; rtag = "R6"; end
                7'h0B: begin e_rdata = {1'b0, m_own, 1'b0, m_dir}; rtag = "R8"; end
                7'h03: begin e_rdata = {11'h0, m_lvl}; rtag = "R9"; end
                default: e_rdata = 16'h0;
            endcase
        end
        chk("R2 R3", "spi pin_out", {9'h0, pin_out[6:0]}, {9'h0, e_out[6:0]});
        chk("R2 R3", "spi pin_oe",  {9'h0, pin_oe[6:0]},  {9'h0, e_oe[6:0]});
        chk("R3", "spi_di", {9'h0, spi_di}, {9'h0, e_di});
        chk("R4", "tx pins", {12'h0, pin_oe[8:7], pin_out[8:7]}, {12'h0, e_oe[8:7], e_out[8:7]});
        chk("R5", "rx pins", {12'h0, pin_oe[10:9], uart_rxd}, {12'h0, e_oe[10:9], e_rxd});
        chk(rtag, "bus_rdata", bus_rdata, e_rdata);
        chk("R9", "spi_irq_lvl", {11'h0, spi_irq_lvl}, {11'h0, m_lvl});
        chk("R12", "xclk_out", {15'h0, xclk_out}, {15'h0, xclk_pin});
    endtask

    task automatic model_edge();
        if (rst) begin
            m_port = '0; m_own = '0; m_dir = '0; m_lvl = '0;
        end else if (bus_sel && bus_we) begin
            case (bus_addr[7:1])
                7'h0A: begin
                    if (bus_be[0]) m_port[7:0]  = bus_wdata[7:0];
                    if (bus_be[1]) m_port[10:8] = bus_wdata[10:8];
                end
                7'h0B: begin
                    if (bus_be[1]) m_own = bus_wdata[14:8];
                    if (bus_be[0]) m_dir = bus_wdata[6:0];
                end
                7'h03: if (bus_be[0]) m_lvl = bus_wdata[4:0];
                default: ;
            endcase
        end
    endtask

    // one cycle: compare settled outputs, cross the edge, update model
    task automatic step();
        #1 compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic bus_idle();
        bus_sel = 0; bus_we = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        step();
        bus_idle();
    endtask

    task automatic rd(input logic [7:0] a);
        bus_sel = 1; bus_we = 0; bus_addr = a; bus_be = 2'b11; bus_wdata = 0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, no requirement completed");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1; bus_idle();
        spi_do = 0; spi_oe = 0; uart_txd = 0; uart_tx_en = 0; uart_rx_en = 0;
        pin_in = 11'h5A5; xclk_pin = 0;
        m_port = '0; m_own = '0; m_dir = '0; m_lvl = '0;
        @(posedge clk); @(negedge clk);
        step(); step();
        rst = 0;
        // R1: reset state at the ports
        chk("R1", "pin_oe after reset", {5'h0, pin_oe}, 16'h0180);
        chk("R1", "level after reset", {11'h0, spi_irq_lvl}, 16'h0);
        rd(8'h16); chk("R1", "cfg read after reset", bus_rdata, 16'h0);
        bus_idle();
        step();

        // R11: level write visible the next cycle
        wr(8'h06, 16'hFFF5, 2'b11);
        rd(8'h06); chk("R11", "level read-back", bus_rdata, 16'h0015);
        step(); bus_idle();

        // R8: byte lanes of the config halfword
        wr(8'h16, 16'hFFFF, 2'b01);
        rd(8'h16); chk("R8", "dir only", bus_rdata, 16'h007F); step();
        wr(8'h16, 16'h2A00, 2'b10);
        rd(8'h17); chk("R8", "own lane, odd addr", bus_rdata, 16'h2A7F); step();

        // R7: latch written while owned, appears after release
        wr(8'h16, 16'h7F7F, 2'b11);
        wr(8'h14, 16'h0055, 2'b11);
        spi_do = 7'h0F; spi_oe = 7'h7F;
        step();
        chk("R3", "owned pins drive spi_do", {9'h0, pin_out[6:0]}, 16'h000F);
        wr(8'h16, 16'h007F, 2'b11);
        chk("R7", "latch after release", {9'h0, pin_out[6:0]}, 16'h0055);

        // R10: unmapped offset write ignored, reads zero
        wr(8'h20, 16'hFFFF, 2'b11);
        rd(8'h20); chk("R10", "unmapped read", bus_rdata, 16'h0);
        rd(8'h14); chk("R10", "port unchanged", bus_rdata, {5'h0, 4'h0, pin_in[10:9] ^ pin_in[10:9], 2'b00, 7'h55} | {5'h0, pin_in[10:9], 9'h0});
        step(); bus_idle();

        // R4 R5: UART enables under both ownership settings
        wr(8'h14, 16'h0180, 2'b11);
        uart_tx_en = 2'b01; uart_txd = 2'b00; uart_rx_en = 2'b10; pin_in = 11'h600;
        step();
        chk("R4", "tx0 carries txd, tx1 latch", {14'h0, pin_out[8:7]}, 16'h0002);
        chk("R5", "rx1 enabled sample", {14'h0, uart_rxd}, 16'h0003);

        // randomised patterns, compared every cycle
        for (int k = 0; k < 4000; k++) begin
            bit [2:0] sel_a;
            sel_a = 3'($urandom_range(0, 5));
            bus_sel   = 1'($urandom);
            bus_we    = 1'($urandom);
            case (sel_a)
                0: bus_addr = 8'h06;
                1: bus_addr = 8'h14;
                2: bus_addr = 8'h15;
                3: bus_addr = 8'h16;
                4: bus_addr = 8'h17;
                default: bus_addr = 8'($urandom);
            endcase
            bus_be    = 2'($urandom);
            bus_wdata = 16'($urandom);
            spi_do    = 7'($urandom);
            spi_oe    = 7'($urandom);
            uart_txd  = 2'($urandom);
            uart_tx_en = 2'($urandom);
            uart_rx_en = 2'($urandom);
            pin_in    = 11'($urandom);
            xclk_pin  = 1'($urandom);
            rst       = ($urandom_range(0, 499) == 0);
            step();
        end
        rst = 0; bus_idle();
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule